// File: doc/BRIEF.md
# Selectable frame check sequence unit

This block adds and verifies the check field carried by variable-length signal units. It has two independent byte paths. On the transmit path, payload octets pass straight through while a cyclic redundancy check (CRC) is computed over them. The check bytes are then appended after the final payload octet, unless generation is switched off. On the receive path, each incoming unit is assumed to end with its check field. That field is always removed before the payload goes on to the receive buffer. When checking is on, a one-cycle error pulse marks units whose check fails.

Either a 16-bit or a 32-bit check can be chosen at run time. Generation and checking each have their own disable. Turning generation off while checking stays on lets a loopback setup confirm that the receiver catches a bad or missing check. Both paths use valid/ready streams with first and last markers and can move one byte per cycle. A transfer happens on a rising edge where valid and ready are both high. A source holds its valid and its data until the transfer takes place. While the transmit path sends check bytes, it drops its upstream ready. Once the receive path holds a full check field's worth of bytes, its upstream ready follows the downstream ready.

Top module: `sigunit_fcs`

## Requirements
- R1: When `cfg_fcs16`=1, the check is the reflected CRC with polynomial x^16+x^12+x^5+1 and 2 check bytes. When `cfg_fcs16`=0, it is the reflected standard CRC-32 with 4 check bytes. In both cases the register is preset to all ones, the result is ones-complemented, and the low byte is sent first with bit 0 as the first bit. The mode is sampled on the first byte of each unit.
- R2: Transmit payload bytes leave unchanged and in order. `m_tx_first` marks the first payload byte. When generation is on, `m_tx_last` marks only the final check byte, and the next unit's bytes follow straight after that byte.
- R3: If `cfg_tx_gen_off`=1 on the last payload beat, no check bytes are sent and `m_tx_last` stays on that payload byte.
- R4: The receive path removes the final 2 or 4 bytes of every unit (per R1's mode) in every configuration. It forwards the rest with `m_rx_first` on the first forwarded byte. `m_rx_last` is set in the same cycle that the unit's final input byte is accepted. Nothing is forwarded on a unit's first input beat.
- R5: When `cfg_rx_chk_off`=0, `rx_fcs_err` pulses high for exactly the one cycle after a unit's final input beat is accepted, and only if the received check does not match.
- R6: When `cfg_rx_chk_off`=1 on a unit's final beat, `rx_fcs_err` stays low for that unit even if the check is wrong.
- R7: While check bytes are being sent, `s_tx_ready` is low and a stalled check byte is held stable. Under any downstream back-pressure pattern, the stream contents on both paths are unchanged.
- R8: After reset, `m_tx_valid`, `m_rx_valid` and `rx_fcs_err` are low, and the transmit path is ready to accept a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fcs16 | input | 1 | 1 selects 16-bit check, 0 selects 32-bit |
| cfg_tx_gen_off | input | 1 | 1 suppresses appending of the check field |
| cfg_rx_chk_off | input | 1 | 1 suppresses check comparison on receive |
| s_tx_valid | input | 1 | Transmit payload byte valid |
| s_tx_ready | output | 1 | Transmit path accepts a byte |
| s_tx_data | input | 8 | Transmit payload byte |
| s_tx_first | input | 1 | First byte of a transmit unit |
| s_tx_last | input | 1 | Last payload byte of a transmit unit |
| m_tx_valid | output | 1 | Outgoing byte valid |
| m_tx_ready | input | 1 | Downstream accepts an outgoing byte |
| m_tx_data | output | 8 | Outgoing byte (payload or check) |
| m_tx_first | output | 1 | First byte of an outgoing unit |
| m_tx_last | output | 1 | Final byte of an outgoing unit |
| s_rx_valid | input | 1 | Received byte valid |
| s_rx_ready | output | 1 | Receive path accepts a byte |
| s_rx_data | input | 8 | Received byte |
| s_rx_first | input | 1 | First byte of a received unit |
| s_rx_last | input | 1 | Final byte (end of check field) of a received unit |
| m_rx_valid | output | 1 | Stripped payload byte valid |
| m_rx_ready | input | 1 | Receive buffer accepts a byte |
| m_rx_data | output | 8 | Stripped payload byte |
| m_rx_first | output | 1 | First payload byte of a unit |
| m_rx_last | output | 1 | Last payload byte of a unit |
| rx_fcs_err | output | 1 | One-cycle check failure pulse |

## Verification
Some properties are checked on every cycle. An error pulse may only follow an accepted final beat, and never one taken while checking was off. A stalled check byte must stay in place while the upstream is held off. The stream must go back to plain pass-through once a unit's final byte leaves, and no payload may come out on a unit's first receive beat. Other behaviour needs the bench's scenarios: that the check values match the polynomials, including a known test string in both modes; that exactly the trailing field is removed for each width, including units with no payload; and that corrupted units raise the flag only when checking is on.

// File: rtl/sigunit_fcs_pkg.sv
package sigunit_fcs_pkg;
  localparam int BYTE_W        = 8;
  localparam int CRC_W         = 32;
  localparam int FCS16_BYTES   = 2;
  localparam int FCS32_BYTES   = 4;
  localparam int FCS_MAX_BYTES = FCS32_BYTES;
  localparam int LEFT_W        = $clog2(FCS_MAX_BYTES);
  localparam int FILL_W        = $clog2(FCS_MAX_BYTES + 1);

  // Reflected (LSB-first) generator constants
  localparam logic [CRC_W-1:0] POLY16_REFL = 32'h0000_8408;
  localparam logic [CRC_W-1:0] POLY32_REFL = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] PRESET16    = 32'h0000_FFFF;
  localparam logic [CRC_W-1:0] PRESET32    = 32'hFFFF_FFFF;
  // Register contents after running over payload plus an intact check field
  localparam logic [CRC_W-1:0] RESIDUE16   = 32'h0000_F0B8;
  localparam logic [CRC_W-1:0] RESIDUE32   = 32'hDEBB_20E3;

  typedef enum logic {TX_PASS, TX_APPEND} tx_state_e;

  function automatic logic [CRC_W-1:0] fcs_preset(input logic narrow);
    return narrow ? PRESET16 : PRESET32;
  endfunction

  function automatic logic [CRC_W-1:0] fcs_residue(input logic narrow);
    return narrow ? RESIDUE16 : RESIDUE32;
  endfunction
endpackage

// File: rtl/fcs_crc_byte.sv
module fcs_crc_byte
  import sigunit_fcs_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] data,
  input  logic              narrow,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] poly;
  logic [BYTE_W:0][CRC_W-1:0] stage;

  assign poly     = narrow ? POLY16_REFL : POLY32_REFL;
  assign stage[0] = crc_in;

  // One shift stage per data bit, bit 0 first
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    logic fb;
    assign fb         = stage[i][0] ^ data[i];
    assign stage[i+1] = (stage[i] >> 1) ^ (fb ? poly : '0);
  end

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/fcs_tx_path.sv
module fcs_tx_path
  import sigunit_fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_narrow,
  input  logic              cfg_gen_off,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_first,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_first,
  output logic              m_last
);
  tx_state_e         state_q;
  logic              narrow_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  shreg_q;
  logic [LEFT_W-1:0] left_q;

  logic              narrow_eff;
  logic [CRC_W-1:0]  crc_base;
  logic [CRC_W-1:0]  crc_next;
  logic              take;

  assign narrow_eff = s_first ? cfg_narrow : narrow_q;
  assign crc_base   = s_first ? fcs_preset(cfg_narrow) : crc_q;

  fcs_crc_byte i_crc (
    .crc_in  (crc_base),
    .data    (s_data),
    .narrow  (narrow_eff),
    .crc_out (crc_next)
  );

  always_comb begin
    if (state_q == TX_APPEND) begin
      m_valid = 1'b1;
      m_data  = shreg_q[BYTE_W-1:0];
      m_first = 1'b0;
      m_last  = (left_q == '0);
      s_ready = 1'b0;
    end else begin
      m_valid = s_valid;
      m_data  = s_data;
      m_first = s_first;
      m_last  = s_last & cfg_gen_off;
      s_ready = m_ready;
    end
  end

  assign take = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TX_PASS;
      narrow_q <= 1'b0;
      crc_q    <= '0;
      shreg_q  <= '0;
      left_q   <= '0;
    end else if (state_q == TX_PASS) begin
      if (take) begin
        crc_q <= crc_next;
        if (s_first) narrow_q <= cfg_narrow;
        if (s_last && !cfg_gen_off) begin
          state_q <= TX_APPEND;
          shreg_q <= ~crc_next;
          left_q  <= narrow_eff ? LEFT_W'(FCS16_BYTES - 1) : LEFT_W'(FCS32_BYTES - 1);
        end
      end
    end else if (m_ready) begin
      shreg_q <= shreg_q >> BYTE_W;
      if (left_q == '0) state_q <= TX_PASS;
      else              left_q  <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/fcs_rx_path.sv
module fcs_rx_path
  import sigunit_fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_narrow,
  input  logic              cfg_chk_off,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_first,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_first,
  output logic              m_last,
  output logic              err_pulse
);
  logic [FCS_MAX_BYTES-1:0][BYTE_W-1:0] hold_q;
  logic [FILL_W-1:0] fill_q;
  logic              narrow_q;
  logic              started_q;
  logic              err_q;
  logic [CRC_W-1:0]  crc_q;

  logic              narrow_eff;
  logic [FILL_W-1:0] need;
  logic              full;
  logic [CRC_W-1:0]  crc_base;
  logic [CRC_W-1:0]  crc_next;
  logic              mismatch;
  logic              take;

  assign narrow_eff = s_first ? cfg_narrow : narrow_q;
  assign need       = narrow_q ? FILL_W'(FCS16_BYTES) : FILL_W'(FCS32_BYTES);
  // Delay line holds exactly one check field: the oldest byte is proven payload
  assign full       = !s_first && (fill_q == need);
  assign crc_base   = s_first ? fcs_preset(cfg_narrow) : crc_q;

  fcs_crc_byte i_crc (
    .crc_in  (crc_base),
    .data    (s_data),
    .narrow  (narrow_eff),
    .crc_out (crc_next)
  );

  assign mismatch  = (crc_next != fcs_residue(narrow_eff));
  assign s_ready   = !full || m_ready;
  assign m_valid   = s_valid && full;
  assign m_data    = narrow_q ? hold_q[FCS16_BYTES-1] : hold_q[FCS32_BYTES-1];
  assign m_first   = !started_q;
  assign m_last    = s_last;
  assign take      = s_valid && s_ready;
  assign err_pulse = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      fill_q    <= '0;
      narrow_q  <= 1'b0;
      started_q <= 1'b0;
      crc_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= take && s_last && !cfg_chk_off && mismatch;
      if (take) begin
        hold_q <= {hold_q[FCS_MAX_BYTES-2:0], s_data};
        crc_q  <= crc_next;
        if (s_first) begin
          fill_q    <= FILL_W'(1);
          narrow_q  <= cfg_narrow;
          started_q <= 1'b0;
        end else begin
          if (!full) fill_q <= fill_q + 1'b1;
          if (m_valid) started_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sigunit_fcs.sv
module sigunit_fcs
  import sigunit_fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fcs16,
  input  logic              cfg_tx_gen_off,
  input  logic              cfg_rx_chk_off,
  input  logic              s_tx_valid,
  output logic              s_tx_ready,
  input  logic [BYTE_W-1:0] s_tx_data,
  input  logic              s_tx_first,
  input  logic              s_tx_last,
  output logic              m_tx_valid,
  input  logic              m_tx_ready,
  output logic [BYTE_W-1:0] m_tx_data,
  output logic              m_tx_first,
  output logic              m_tx_last,
  input  logic              s_rx_valid,
  output logic              s_rx_ready,
  input  logic [BYTE_W-1:0] s_rx_data,
  input  logic              s_rx_first,
  input  logic              s_rx_last,
  output logic              m_rx_valid,
  input  logic              m_rx_ready,
  output logic [BYTE_W-1:0] m_rx_data,
  output logic              m_rx_first,
  output logic              m_rx_last,
  output logic              rx_fcs_err
);
  fcs_tx_path i_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_narrow  (cfg_fcs16),
    .cfg_gen_off (cfg_tx_gen_off),
    .s_valid     (s_tx_valid),
    .s_ready     (s_tx_ready),
    .s_data      (s_tx_data),
    .s_first     (s_tx_first),
    .s_last      (s_tx_last),
    .m_valid     (m_tx_valid),
    .m_ready     (m_tx_ready),
    .m_data      (m_tx_data),
    .m_first     (m_tx_first),
    .m_last      (m_tx_last)
  );

  fcs_rx_path i_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_narrow  (cfg_fcs16),
    .cfg_chk_off (cfg_rx_chk_off),
    .s_valid     (s_rx_valid),
    .s_ready     (s_rx_ready),
    .s_data      (s_rx_data),
    .s_first     (s_rx_first),
    .s_last      (s_rx_last),
    .m_valid     (m_rx_valid),
    .m_ready     (m_rx_ready),
    .m_data      (m_rx_data),
    .m_first     (m_rx_first),
    .m_last      (m_rx_last),
    .err_pulse   (rx_fcs_err)
  );
endmodule

// File: rtl/sigunit_fcs_chk.sv
module sigunit_fcs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_rx_chk_off,
  input logic       s_tx_valid,
  input logic       s_tx_ready,
  input logic       m_tx_valid,
  input logic       m_tx_ready,
  input logic [7:0] m_tx_data,
  input logic       m_tx_last,
  input logic       s_rx_valid,
  input logic       s_rx_ready,
  input logic       s_rx_first,
  input logic       s_rx_last,
  input logic       m_rx_valid,
  input logic       rx_fcs_err
);
  AST_ERR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fcs_err |-> $past(s_rx_valid && s_rx_ready && s_rx_last)); // R5

  AST_ERR_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fcs_err |-> !$past(cfg_rx_chk_off)); // R6

  AST_TX_HOLD_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tx_valid && !s_tx_valid && !m_tx_ready) |=> (m_tx_valid && !s_tx_ready && $stable(m_tx_data))); // R7

  AST_TX_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tx_valid && m_tx_ready && m_tx_last) |=> (m_tx_valid == s_tx_valid)); // R2

  AST_RX_NONE_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rx_valid && s_rx_first) |-> !m_rx_valid); // R4
endmodule

bind sigunit_fcs sigunit_fcs_chk i_chk (.*);

// File: tb/test_sigunit_fcs.sv
`timescale 1ns/1ps
module test_sigunit_fcs;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic cfg_fcs16, cfg_tx_gen_off, cfg_rx_chk_off;
  logic s_tx_valid, s_tx_ready, s_tx_first, s_tx_last;
  logic [7:0] s_tx_data;
  logic m_tx_valid, m_tx_ready, m_tx_first, m_tx_last;
  logic [7:0] m_tx_data;
  logic s_rx_valid, s_rx_ready, s_rx_first, s_rx_last;
  logic [7:0] s_rx_data;
  logic m_rx_valid, m_rx_ready, m_rx_first, m_rx_last;
  logic [7:0] m_rx_data;
  logic rx_fcs_err;

  sigunit_fcs i_sigunit_fcs (.*);

  typedef struct packed {logic [7:0] d; logic f; logic l; logic fcs;} beat_t;
  beat_t txq[$];
  beat_t rxq[$];
  int checks = 0, fails = 0, err_exp = 0, err_seen = 0;
  bit tx_rand = 0, rx_rand = 0;
  logic [7:0] pay [0:63];

  // Independent reference: non-reflected MSB-first register, output bit-reversed
  function automatic logic [31:0] ref_fcs(input int n, input bit narrow);
    int w;
    logic [31:0] poly, msk, c, r;
    bit fb;
    w = narrow ? 16 : 32;
    poly = narrow ? 32'h0000_1021 : 32'h04C1_1DB7;
    msk = narrow ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    c = msk;
    r = '0;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        fb = c[w-1] ^ pay[k][b];
        c = (c << 1) & msk;
        if (fb) c = c ^ poly;
      end
    c = ~c & msk;
    for (int i = 0; i < w; i++) r[i] = c[w-1-i];
    return r;
  endfunction

  task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  task automatic drive_tx(input logic [7:0] d, input bit f, input bit l);
    s_tx_valid = 1; s_tx_data = d; s_tx_first = f; s_tx_last = l;
    forever begin @(negedge clk); if (s_tx_ready) break; end
    @(posedge clk); #1;
    s_tx_valid = 0; s_tx_first = 0; s_tx_last = 0;
  endtask

  task automatic drive_rx(input logic [7:0] d, input bit f, input bit l);
    s_rx_valid = 1; s_rx_data = d; s_rx_first = f; s_rx_last = l;
    forever begin @(negedge clk); if (s_rx_ready) break; end
    @(posedge clk); #1;
    s_rx_valid = 0; s_rx_first = 0; s_rx_last = 0;
  endtask

  // R1 R2 R3: push expected beats, then drive the payload
  task automatic run_tx(input int n, input bit narrow, input bit goff);
    logic [31:0] f;
    int nb;
    cfg_fcs16 = narrow; cfg_tx_gen_off = goff;
    f = ref_fcs(n, narrow);
    nb = narrow ? 2 : 4;
    for (int i = 0; i < n; i++) txq.push_back({pay[i], i == 0, goff && (i == n-1), 1'b0});
    if (!goff)
      for (int j = 0; j < nb; j++) txq.push_back({f[8*j +: 8], 1'b0, j == nb-1, 1'b1});
    for (int i = 0; i < n; i++) drive_tx(pay[i], i == 0, i == n-1);
  endtask

  // R4 R5 R6: payload plus check field (optionally corrupted)
  task automatic run_rx(input int n, input bit narrow, input bit choff, input bit corrupt);
    logic [31:0] f;
    int nb;
    bit e;
    cfg_fcs16 = narrow; cfg_rx_chk_off = choff;
    f = ref_fcs(n, narrow);
    if (corrupt) f[3] = ~f[3];
    nb = narrow ? 2 : 4;
    e = corrupt && !choff;
    if (e) err_exp++;
    for (int i = 0; i < n; i++) rxq.push_back({pay[i], i == 0, i == n-1, 1'b0});
    for (int i = 0; i < n + nb; i++)
      drive_rx(i < n ? pay[i] : f[8*(i-n) +: 8], i == 0, i == n+nb-1);
    @(negedge clk);
    check(rx_fcs_err == e, choff ? "R6 error flag with checking off" : "R5 error flag at end of unit",
          32'(rx_fcs_err), 32'(e));
  endtask

  // Monitors: scoreboard comparison at the falling edge before each transfer
  always @(negedge clk) begin
    beat_t e;
    if (rst_n && m_tx_valid && m_tx_ready) begin
      if (txq.size() == 0) check(0, "R2 unexpected tx beat", 32'(m_tx_data), 0);
      else begin
        e = txq.pop_front();
        check(m_tx_data == e.d && m_tx_first == e.f && m_tx_last == e.l,
              e.fcs ? "R1 tx check byte" : "R2/R3 tx payload byte",
              {22'd0, m_tx_first, m_tx_last, m_tx_data}, {22'd0, e.f, e.l, e.d});
        if (e.fcs) check(!s_tx_ready, "R7 upstream held during append", 32'(s_tx_ready), 0);
      end
    end
    if (rst_n && m_rx_valid && m_rx_ready) begin
      if (rxq.size() == 0) check(0, "R4 unexpected rx beat", 32'(m_rx_data), 0);
      else begin
        e = rxq.pop_front();
        check(m_rx_data == e.d && m_rx_first == e.f && m_rx_last == e.l, "R4 rx stripped byte",
              {22'd0, m_rx_first, m_rx_last, m_rx_data}, {22'd0, e.f, e.l, e.d});
      end
    end
    if (rst_n && rx_fcs_err) err_seen++;
  end

  always @(posedge clk) begin
    #1;
    m_tx_ready = tx_rand ? ($urandom % 3 != 0) : 1'b1;
    m_rx_ready = rx_rand ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_fcs16 = 1; cfg_tx_gen_off = 0; cfg_rx_chk_off = 0;
    s_tx_valid = 0; s_tx_data = 0; s_tx_first = 0; s_tx_last = 0;
    s_rx_valid = 0; s_rx_data = 0; s_rx_first = 0; s_rx_last = 0;
    m_tx_ready = 1; m_rx_ready = 1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R8 reset state
    check(!m_tx_valid, "R8 m_tx_valid after reset", 32'(m_tx_valid), 0);
    check(!m_rx_valid, "R8 m_rx_valid after reset", 32'(m_rx_valid), 0);
    check(!rx_fcs_err, "R8 rx_fcs_err after reset", 32'(rx_fcs_err), 0);
    check(s_tx_ready, "R8 s_tx_ready after reset", 32'(s_tx_ready), 1);

    // R1 reference sanity on the string "123456789"
    for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    check(ref_fcs(9, 1) == 32'h0000_906E, "R1 reference 16-bit", ref_fcs(9, 1), 32'h0000_906E);
    check(ref_fcs(9, 0) == 32'hCBF4_3926, "R1 reference 32-bit", ref_fcs(9, 0), 32'hCBF4_3926);
    @(posedge clk); #1;
    run_tx(9, 1, 0);   // R1 16-bit
    run_tx(9, 0, 0);   // R1 32-bit
    run_tx(9, 1, 1);   // R3 no check appended
    for (int i = 0; i < 64; i++) pay[i] = 8'($urandom);
    run_tx(1, 0, 0);
    run_tx(1, 1, 1);
    tx_rand = 1;       // R7 back-pressure
    run_tx(17, 0, 0);
    run_tx(5, 1, 0);
    run_tx(12, 0, 1);
    run_tx(30, 1, 0);
    wait (txq.size() == 0);
    tx_rand = 0;

    run_rx(9, 1, 0, 0);   // R4 R5 good 16-bit
    run_rx(9, 0, 0, 0);   // R4 good 32-bit
    run_rx(6, 1, 0, 1);   // R5 bad 16-bit
    run_rx(6, 0, 0, 1);   // R5 bad 32-bit
    run_rx(7, 1, 1, 1);   // R6 bad, checking off
    run_rx(7, 0, 1, 0);   // R6 good, checking off
    run_rx(0, 1, 0, 0);   // R4 check field only
    run_rx(0, 0, 0, 1);
    run_rx(1, 0, 0, 0);
    rx_rand = 1;          // R7 back-pressure on receive
    run_rx(20, 0, 0, 0);
    run_rx(13, 1, 0, 1);
    run_rx(25, 1, 1, 0);
    wait (rxq.size() == 0);
    rx_rand = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(err_seen == err_exp, "R6 total error pulses", 32'(err_seen), 32'(err_exp));
    check(txq.size() == 0 && rxq.size() == 0, "R2/R4 scoreboard drained",
          32'(txq.size() + rxq.size()), 0);
    finish_run();
  end
endmodule